// File: doc/BRIEF.md
# Gain-Hopping Burst-Mode Controller

This controller supervises a switched-capacitor charge pump that regulates in burst mode. At every regulator sample strobe it reads one comparator bit that says whether the regulated output is below its target. When the output is low, it drives the pump-enable output for that regulator cycle. When the output is high, it drives the skip output and the switch array stays idle.

The pump requests also feed an up/down counter. Each pump sample moves the counter up and each skip sample moves it down. A long run of pump samples means the present gain cannot carry the load, so the counter moves the gain one step up. A long run of skip samples moves the gain one step down. The seven gain settings are indexed from 0 to 6 in ascending order of ratio: 1/2, 2/3, 3/4, 1, 4/3, 3/2, 2.

An input-voltage range detector supplies a floor index. The floor keeps the gain high enough that the ideal output stays above the regulated voltage. The gain never rests below this floor. The floor lets the controller stay at the lowest usable gain whenever the load allows it.

Top module: `gain_hop_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `pump_en` and `skip` are 0 and `gain_idx` equals the clamped floor. The step counter starts at its midpoint, so exactly HALF_SPAN consecutive pump samples are needed for the first step up.
- R2: On a clock edge where `tick` is 1, `pump_en` takes the value of `cmp_below` and `skip` takes its inverse. Both are visible from the next cycle on.
- R3: On edges where `tick` is 0, `cmp_below` is ignored. `pump_en`, `skip` and the step counter keep their values.
- R4: Each sampled pump adds one to the counter and each sampled skip subtracts one. When a pump sample makes the counter reach 2*HALF_SPAN, the counter returns to HALF_SPAN and `gain_idx` rises by one on the same edge.
- R5: When a skip sample makes the counter reach 0, the counter returns to HALF_SPAN and `gain_idx` falls by one on the same edge.
- R6: `gain_idx` never exceeds 6. An up step at index 6 leaves the gain at 6, and the counter still recentres.
- R7: A down step when `gain_idx` already equals the floor leaves the gain unchanged, and the counter still recentres.
- R8: If the floor rises above `gain_idx`, `gain_idx` takes the floor value on the next clock edge, with or without a tick. Lowering the floor never lowers the gain by itself.
- R9: The floor is `min_gain_idx` clamped to 6, so the input value 7 acts as 6.
- R10: Without a tick, `gain_idx` changes only by jumping to the floor. With a tick, it moves by at most one step unless it jumps to the floor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle regulator sample strobe |
| cmp_below | input | 1 | Comparator bit: 1 when the output is below the target |
| min_gain_idx | input | 3 | Floor index from the input-voltage range detector |
| pump_en | output | 1 | Registered: switch array delivers charge this regulator cycle |
| skip | output | 1 | Registered: switch array rests this regulator cycle |
| gain_idx | output | 3 | Registered gain index, 0 (1/2) to 6 (2) |

## Verification
The bench builds the controller with HALF_SPAN = 4, so a gain step needs only four net samples. This lets a few hundred ticks drive the gain across all seven levels into both saturation points. Every floor value from 0 to 7 is swept. Each sweep uses pump-heavy and skip-heavy pseudo-random sample streams and idle gaps with a toggling comparator. A floor raise in the middle of each run checks the immediate jump, and a later floor drop checks that the gain does not fall on its own.

// File: rtl/gain_hop_pkg.sv
package gain_hop_pkg;
  localparam int NUM_GAINS = 7;
  localparam int GAIN_W    = 3;
  localparam logic [GAIN_W-1:0] MAX_IDX = GAIN_W'(NUM_GAINS - 1);

  typedef logic [GAIN_W-1:0] gain_idx_t;

  typedef struct packed {
    logic up;
    logic dn;
  } step_req_t;

  function automatic gain_idx_t clamp_floor(input gain_idx_t raw);
    return (raw > MAX_IDX) ? MAX_IDX : raw;
  endfunction
endpackage

// File: rtl/gh_sampler.sv
module gh_sampler (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cmp_below,
  output logic pump_en,
  output logic skip
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pump_en <= 1'b0;
      skip    <= 1'b0;
    end else if (tick) begin
      pump_en <= cmp_below;
      skip    <= ~cmp_below;
    end
  end
endmodule

// File: rtl/gh_density_cnt.sv
module gh_density_cnt
  import gain_hop_pkg::*;
#(
  parameter int HALF_SPAN = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      cmp_below,
  output step_req_t step
);
  localparam int CNT_W = $clog2(2 * HALF_SPAN + 1);
  localparam logic [CNT_W-1:0] MID      = CNT_W'(HALF_SPAN);
  localparam logic [CNT_W-1:0] NEAR_TOP = CNT_W'(2 * HALF_SPAN - 1);
  localparam logic [CNT_W-1:0] NEAR_BOT = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  step_req_t        step_c;

  always_comb begin
    step_c.up = tick &  cmp_below & (cnt_q == NEAR_TOP);
    step_c.dn = tick & ~cmp_below & (cnt_q == NEAR_BOT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= MID;
    end else if (step_c.up || step_c.dn) begin
      cnt_q <= MID;
    end else if (tick) begin
      cnt_q <= cmp_below ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
    end
  end

  assign step = step_c;
endmodule

// File: rtl/gh_gain_set.sv
module gh_gain_set
  import gain_hop_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  step_req_t step,
  input  gain_idx_t min_gain_idx,
  output gain_idx_t gain_idx
);
  gain_idx_t floor_c;
  gain_idx_t gain_q;
  gain_idx_t gain_d;

  assign floor_c = clamp_floor(min_gain_idx);

  always_comb begin
    gain_d = gain_q;
    if (gain_q < floor_c) begin
      gain_d = floor_c;
    end else if (step.up && (gain_q < MAX_IDX)) begin
      gain_d = gain_q + GAIN_W'(1);
    end else if (step.dn && (gain_q > floor_c)) begin
      gain_d = gain_q - GAIN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gain_q <= floor_c;
    else     gain_q <= gain_d;
  end

  assign gain_idx = gain_q;
endmodule

// File: rtl/gain_hop_ctrl.sv
module gain_hop_ctrl
  import gain_hop_pkg::*;
#(
  parameter int HALF_SPAN = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        cmp_below,
  input  logic [2:0]  min_gain_idx,
  output logic        pump_en,
  output logic        skip,
  output logic [2:0]  gain_idx
);
  step_req_t step_w;

  gh_sampler u_sampler (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cmp_below (cmp_below),
    .pump_en   (pump_en),
    .skip      (skip)
  );

  gh_density_cnt #(.HALF_SPAN(HALF_SPAN)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cmp_below (cmp_below),
    .step      (step_w)
  );

  gh_gain_set u_gain (
    .clk          (clk),
    .rst          (rst),
    .step         (step_w),
    .min_gain_idx (min_gain_idx),
    .gain_idx     (gain_idx)
  );
endmodule

// File: rtl/gain_hop_chk.sv
module gain_hop_chk
  import gain_hop_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       cmp_below,
  input logic [2:0] min_gain_idx,
  input logic       pump_en,
  input logic       skip,
  input logic [2:0] gain_idx
);
  // R2
  tick_sample_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (pump_en == $past(cmp_below)) && (skip == !$past(cmp_below)));

  // R2
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(pump_en && skip));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pump_en) && $stable(skip));

  // R6
  gain_cap_chk: assert property (@(posedge clk) disable iff (rst)
    gain_idx <= MAX_IDX);

  // R7
  gain_floor_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> gain_idx >= clamp_floor($past(min_gain_idx)));

  // R10
  idle_gain_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (gain_idx == $past(gain_idx)) ||
              (gain_idx == clamp_floor($past(min_gain_idx))));

  // R10
  gain_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (gain_idx == clamp_floor($past(min_gain_idx))) ||
             ({1'b0, gain_idx} <= {1'b0, $past(gain_idx)} + 4'd1 &&
              {1'b0, gain_idx} + 4'd1 >= {1'b0, $past(gain_idx)}));
endmodule

bind gain_hop_ctrl gain_hop_chk u_gain_hop_chk (
  .clk          (clk),
  .rst          (rst),
  .tick         (tick),
  .cmp_below    (cmp_below),
  .min_gain_idx (min_gain_idx),
  .pump_en      (pump_en),
  .skip         (skip),
  .gain_idx     (gain_idx)
);

// File: tb/test_gain_hop_ctrl.sv
module test_gain_hop_ctrl;
  localparam int HS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       cmp_below = 1'b0;
  logic [2:0] min_gain_idx = 3'd0;
  logic       pump_en;
  logic       skip;
  logic [2:0] gain_idx;

  int vec_cnt = 0;
  int bad_cnt = 0;
  int m_cnt;
  int m_gain;
  logic m_pump;
  logic m_skip;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  gain_hop_ctrl #(.HALF_SPAN(HS)) i_gain_hop_ctrl (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .cmp_below    (cmp_below),
    .min_gain_idx (min_gain_idx),
    .pump_en      (pump_en),
    .skip         (skip),
    .gain_idx     (gain_idx)
  );

  function automatic int flr(input int raw);
    return (raw > 6) ? 6 : raw;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vec_cnt++;
    if (act != exp) begin
      bad_cnt++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // reference model of one clock edge
  task automatic model_edge(input logic t, input logic b);
    bit up = 0;
    bit dn = 0;
    int fl = flr(int'(min_gain_idx));
    if (t) begin
      m_pump = b;
      m_skip = !b;
      if (b) m_cnt++; else m_cnt--;
      if (m_cnt == 2 * HS) begin up = 1; m_cnt = HS; end
      else if (m_cnt == 0) begin dn = 1; m_cnt = HS; end
    end
    if (m_gain < fl) m_gain = fl;
    else if (up && m_gain < 6) m_gain++;
    else if (dn && m_gain > fl) m_gain--;
  endtask

  task automatic do_reset(input int mg);
    @(negedge clk);
    rst = 1'b1;
    tick = 1'b0;
    min_gain_idx = 3'(mg);
    @(posedge clk);
    @(negedge clk);
    m_cnt = HS; m_gain = flr(mg); m_pump = 0; m_skip = 0;
    // R1: values during reset; R9 clamp applies
    chk("R1/R9 gain in reset", int'(gain_idx), m_gain);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 pump_en after reset", int'(pump_en), 0);
    chk("R1 skip after reset", int'(skip), 0);
    chk("R1/R9 gain after reset", int'(gain_idx), m_gain);
  endtask

  task automatic do_tick(input logic b);
    tick = 1'b1;
    cmp_below = b;
    @(posedge clk);
    model_edge(1'b1, b);
    @(negedge clk);
    tick = 1'b0;
    chk("R2 pump_en", int'(pump_en), int'(m_pump));
    chk("R2 skip", int'(skip), int'(m_skip));
    chk("R4/R5/R6/R7 gain", int'(gain_idx), m_gain);
  endtask

  task automatic do_idle(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b0;
      cmp_below = ~cmp_below;
      @(posedge clk);
      model_edge(1'b0, 1'b0);
      @(negedge clk);
      chk("R3 pump_en held", int'(pump_en), int'(m_pump));
      chk("R3 skip held", int'(skip), int'(m_skip));
      chk("R8/R10 gain idle", int'(gain_idx), m_gain);
    end
  endtask

  initial begin
    #(20 * 200000);
    bad_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    for (int mg = 0; mg < 8; mg++) begin
      do_reset(mg);
      // R1: exactly HS pumps from midpoint give first up step
      for (int i = 0; i < HS; i++) do_tick(1'b1);
      // pump-heavy phase to reach saturation (R4, R6)
      for (int i = 0; i < 80; i++) begin
        lfsr_step();
        do_tick(lfsr[1:0] != 2'b00);
        if (lfsr[2]) do_idle(int'(lfsr[4:3]));
      end
      // skip-heavy phase down to the floor (R5, R7)
      for (int i = 0; i < 80; i++) begin
        lfsr_step();
        do_tick(lfsr[1:0] == 2'b00);
        if (lfsr[2]) do_idle(int'(lfsr[4:3]));
      end
      // R8: raise floor, gain jumps on an idle edge
      min_gain_idx = 3'((mg + 2 > 7) ? 7 : mg + 2);
      do_idle(2);
      // R8: drop floor, gain must not fall by itself
      min_gain_idx = 3'(mg);
      do_idle(3);
      for (int i = 0; i < 60; i++) begin
        lfsr_step();
        do_tick(lfsr[0]);
      end
      for (int i = 0; i < 40; i++) do_tick(1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end
endmodule